// File: doc/BRIEF.md
# Paged memory window decoder

This block decodes host bus cycles for a battery-backed memory card of up to 2 MB on an ISA-style bus. The host programs two registers through an 8-byte I/O block whose base is set by two strap inputs: a page register that picks one of 64 banks of 32 KB, and a mode register.

The mode register chooses how the card appears in host memory space. It can be absent, shown as a 32 KB window at one of eight bases, or mapped as one flat 2 MB region. In window mode a strap-like mode bit selects the compare width. With the narrow compare, A19..A15 are matched against slots from 0xA0000 to 0xD8000. With the wide compare, A21..A15 are matched against a base of select × 0x8000.

The chip-select and the 21-bit memory address are purely combinational from the host address and the stored registers. A read-only status byte returns the two LED states.

Top module: `pwd_decoder`

## Requirements
- R1: After reset the page register and the mode register both read 0x00, and `mem_cs` stays low for every host address.
- R2: The I/O block base is 0x140, plus 0x08 when `io_base_cfg[0]` is set, plus 0x20 when `io_base_cfg[1]` is set. The block spans base to base+7. Accesses outside it neither write a register nor drive `io_rdata_oe`.
- R3: The page register is at offset 4 and holds 6 bits. A write stores `io_wdata[5:0]`, and reads return bits 7:6 as zero.
- R4: The mode register is at offset 5. Its fields are: bit 7 linear, bit 6 paged, bit 5 test, bit 4 reserved (reads 0, writes ignored), bit 3 wide-decode, and bits 2:0 window select.
- R5: The read-only status byte is at offset 3. Bit 0 is `led_red`, bit 1 is `led_green`, and bits 7:2 are zero.
- R6: A read of offset 0, 1, 2, 6 or 7 leaves `io_rdata_oe` low, and `io_rdata` is 0x00 whenever `io_rdata_oe` is low.
- R7: With both the linear bit and the paged bit clear, `mem_cs` is never asserted.
- R8: In paged mode with wide-decode clear, the window starts at 0xA0000 + select × 0x8000. Only A19..A15 are compared, so A21..A20 are ignored.
- R9: In paged mode with wide-decode set, A21..A15 must equal {0000, select}. The window therefore starts at select × 0x8000.
- R10: On a paged hit, `mem_addr` equals {page, A14..A0}.
- R11: With the linear bit set, the paged and select fields are ignored. `mem_cs` follows A21, and `mem_addr` equals A20..A0.
- R12: `mem_cs` and `mem_addr` follow `host_addr` in the same cycle, with no clock edge between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_base_cfg | input | 2 | Strap selecting the I/O block base |
| io_addr | input | 10 | Host I/O address |
| io_wr | input | 1 | I/O write strobe, sampled on the clock |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (0 when not driven) |
| io_rdata_oe | output | 1 | Drive enable for the read data |
| led_red | input | 1 | Red LED state for status readback |
| led_green | input | 1 | Green LED state for status readback |
| host_addr | input | 22 | Host memory address |
| mem_cs | output | 1 | Memory chip-select |
| mem_addr | output | 21 | Memory device address |

## Verification
The decode table combines each mode with host addresses chosen to separate the modes from one another:
- The same address 0xB8010 hits with narrow decode and misses with wide decode.
- An address with A21 set hits in narrow paged mode and in linear mode, but misses in wide paged mode.
- An address with A21 clear in the legacy range misses once the linear bit overrides paged.
- Page values of 0, 1, 2, 5 and 63 show the page number in every upper address bit.

Directed tests cover the four I/O bases, the unmapped offsets, the masking of the reserved and upper bits, reset in the middle of a run, and a host address change with no clock edge.

// File: rtl/pwd_pkg.sv
package pwd_pkg;
  localparam int PAGE_W = 6;
  localparam int WIN_W  = 15;
  localparam int HOST_W = 22;
  localparam int MEM_W  = PAGE_W + WIN_W;
  localparam int IO_W   = 10;
  localparam int SEL_W  = 3;
  localparam int NARROW_HI = 19;
  localparam int WIDE_HI   = HOST_W - 1;
  localparam logic [NARROW_HI-WIN_W:0] LEGACY_SLOT = 5'd20;

  localparam logic [2:0] OFS_STATUS = 3'd3;
  localparam logic [2:0] OFS_PAGE   = 3'd4;
  localparam logic [2:0] OFS_MODE   = 3'd5;

  typedef struct packed {
    logic             linear;
    logic             paged;
    logic             test;
    logic             rsvd;
    logic             wide;
    logic [SEL_W-1:0] sel;
  } mode_t;

  function automatic logic [IO_W-1:0] io_base_of(input logic [IO_W-1:0] lo,
                                                 input logic [1:0] cfg);
    logic [IO_W-1:0] b;
    b = lo;
    if (cfg[0]) b = b + 10'h008;
    if (cfg[1]) b = b + 10'h020;
    return b;
  endfunction

  function automatic logic paged_match(input logic [HOST_W-1:0] a,
                                       input logic [SEL_W-1:0] sel,
                                       input logic wide);
    if (wide)
      return a[WIDE_HI:WIN_W] == {{(WIDE_HI-WIN_W+1-SEL_W){1'b0}}, sel};
    else
      return a[NARROW_HI:WIN_W] == (LEGACY_SLOT + {{(NARROW_HI-WIN_W+1-SEL_W){1'b0}}, sel});
  endfunction
endpackage

// File: rtl/pwd_io_regs.sv
module pwd_io_regs
  import pwd_pkg::*;
#(
  parameter logic [IO_W-1:0] IO_BASE_LO = 10'h140
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        io_base_cfg,
  input  logic [IO_W-1:0]   io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  input  logic              led_red,
  input  logic              led_green,
  output logic [7:0]        io_rdata,
  output logic              io_rdata_oe,
  output logic [PAGE_W-1:0] page_q,
  output mode_t             mode_q,
  output logic              io_hit,
  output logic              wr_page,
  output logic              wr_mode
);
  localparam int BLK_LSB = 3;

  logic [IO_W-1:0] base;
  logic [2:0]      ofs;
  logic [7:0]      rd_mux;
  logic            rd_valid;

  assign base    = io_base_of(IO_BASE_LO, io_base_cfg);
  assign io_hit  = io_addr[IO_W-1:BLK_LSB] == base[IO_W-1:BLK_LSB];
  assign ofs     = io_addr[BLK_LSB-1:0];
  assign wr_page = io_wr && io_hit && (ofs == OFS_PAGE);
  assign wr_mode = io_wr && io_hit && (ofs == OFS_MODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      mode_q <= '0;
    end else begin
      if (wr_page) page_q <= io_wdata[PAGE_W-1:0];
      if (wr_mode) begin
        mode_q      <= mode_t'(io_wdata);
        mode_q.rsvd <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_mux   = 8'h00;
    rd_valid = 1'b1;
    unique case (ofs)
      OFS_STATUS: rd_mux = {6'b0, led_green, led_red};
      OFS_PAGE:   rd_mux = {{(8-PAGE_W){1'b0}}, page_q};
      OFS_MODE:   rd_mux = mode_q;
      default:    rd_valid = 1'b0;
    endcase
  end

  assign io_rdata_oe = io_rd && io_hit && rd_valid;
  assign io_rdata    = io_rdata_oe ? rd_mux : 8'h00;
endmodule

// File: rtl/pwd_window_dec.sv
module pwd_window_dec
  import pwd_pkg::*;
(
  input  mode_t             mode_q,
  input  logic [PAGE_W-1:0] page_q,
  input  logic [HOST_W-1:0] host_addr,
  output logic              hit_linear,
  output logic              hit_paged,
  output logic              mem_cs,
  output logic [MEM_W-1:0]  mem_addr
);
  assign hit_linear = mode_q.linear && host_addr[HOST_W-1];
  assign hit_paged  = !mode_q.linear && mode_q.paged &&
                      paged_match(host_addr, mode_q.sel, mode_q.wide);
  assign mem_cs     = hit_linear || hit_paged;

  always_comb begin
    if (mode_q.linear) mem_addr = host_addr[MEM_W-1:0];
    else               mem_addr = {page_q, host_addr[WIN_W-1:0]};
  end
endmodule

// File: rtl/pwd_decoder.sv
module pwd_decoder
  import pwd_pkg::*;
#(
  parameter logic [9:0] IO_BASE_LO = 10'h140
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  io_base_cfg,
  input  logic [9:0]  io_addr,
  input  logic        io_wr,
  input  logic        io_rd,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  output logic        io_rdata_oe,
  input  logic        led_red,
  input  logic        led_green,
  input  logic [21:0] host_addr,
  output logic        mem_cs,
  output logic [20:0] mem_addr
);
  logic [PAGE_W-1:0] page_q;
  mode_t             mode_q;
  logic              io_hit, wr_page, wr_mode;
  logic              hit_linear, hit_paged;

  pwd_io_regs #(.IO_BASE_LO(IO_BASE_LO)) u_regs (
    .clk(clk), .rst_n(rst_n), .io_base_cfg(io_base_cfg), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
    .led_red(led_red), .led_green(led_green),
    .io_rdata(io_rdata), .io_rdata_oe(io_rdata_oe),
    .page_q(page_q), .mode_q(mode_q),
    .io_hit(io_hit), .wr_page(wr_page), .wr_mode(wr_mode)
  );

  pwd_window_dec u_dec (
    .mode_q(mode_q), .page_q(page_q), .host_addr(host_addr),
    .hit_linear(hit_linear), .hit_paged(hit_paged),
    .mem_cs(mem_cs), .mem_addr(mem_addr)
  );
endmodule

// File: rtl/pwd_decoder_chk.sv
module pwd_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  mode_v,
  input logic [5:0]  page_v,
  input logic        wr_page,
  input logic        io_rd,
  input logic        io_rdata_oe,
  input logic [21:0] host_addr,
  input logic        mem_cs,
  input logic [20:0] mem_addr
);
  // R7
  off_mode_no_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_v[7] && !mode_v[6]) |-> !mem_cs);
  // R10
  paged_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cs && !mode_v[7]) |-> (mem_addr == {page_v, host_addr[14:0]}));
  // R11
  linear_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cs && mode_v[7]) |-> (host_addr[21] && mem_addr == host_addr[20:0]));
  // R6
  rdata_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_rdata_oe |-> io_rd);
  // R3
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_page) |-> $stable(page_v));
  // R4
  mode_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_v[4]);
endmodule

bind pwd_decoder pwd_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_v(mode_q), .page_v(page_q),
  .wr_page(wr_page), .io_rd(io_rd), .io_rdata_oe(io_rdata_oe),
  .host_addr(host_addr), .mem_cs(mem_cs), .mem_addr(mem_addr)
);

// File: tb/pwd_decoder_bench.sv
module pwd_decoder_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  io_base_cfg = 2'b00;
  logic [9:0]  io_addr = '0;
  logic        io_wr = 0, io_rd = 0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        io_rdata_oe;
  logic        led_red = 0, led_green = 0;
  logic [21:0] host_addr = '0;
  logic        mem_cs;
  logic [20:0] mem_addr;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwd_decoder u_pwd_decoder (
    .clk(clk), .rst_n(rst_n), .io_base_cfg(io_base_cfg), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .io_rdata_oe(io_rdata_oe), .led_red(led_red), .led_green(led_green),
    .host_addr(host_addr), .mem_cs(mem_cs), .mem_addr(mem_addr)
  );

  // {mode, page, host address, expected cs, expected memory address}
  localparam int NV = 15;
  localparam logic [57:0] VEC [0:NV-1] = '{
    {8'h00, 6'd0,  22'h0A0000, 1'b0, 21'h000000},  // R7 off
    {8'h40, 6'd5,  22'h0A1234, 1'b1, 21'h029234},  // R8 slot 0
    {8'h40, 6'd5,  22'h0A8000, 1'b0, 21'h000000},  // R8 next slot
    {8'h46, 6'd63, 22'h0D7FFF, 1'b1, 21'h1FFFFF},  // R8 R10
    {8'h46, 6'd63, 22'h3D0001, 1'b1, 21'h1F8001},  // R8 A21..A20 ignored
    {8'h47, 6'd1,  22'h0D8000, 1'b1, 21'h008000},  // R8 slot 7
    {8'h4B, 6'd2,  22'h018010, 1'b1, 21'h010010},  // R9
    {8'h4B, 6'd2,  22'h218010, 1'b0, 21'h000000},  // R9 A21 compared
    {8'h4B, 6'd2,  22'h0B8010, 1'b0, 21'h000000},  // R9 vs narrow
    {8'h43, 6'd2,  22'h0B8010, 1'b1, 21'h010010},  // R8 same address narrow
    {8'h80, 6'd9,  22'h212345, 1'b1, 21'h012345},  // R11
    {8'hC6, 6'd9,  22'h0D0000, 1'b0, 21'h000000},  // R11 paged ignored
    {8'hC6, 6'd9,  22'h3FFFFF, 1'b1, 21'h1FFFFF},  // R11
    {8'h20, 6'd0,  22'h0A0000, 1'b0, 21'h000000},  // R7 test bit only
    {8'h08, 6'd0,  22'h000000, 1'b0, 21'h000000}   // R7 decode bit only
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk);
    io_wr = 0;
  endtask

  task automatic io_read(input logic [9:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    io_addr = a; io_rd = 1;
    #1;
    d = io_rdata; oe = io_rdata_oe;
    io_rd = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    logic oe;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    io_read(10'h144, d, oe); chk("R1 page", d, 8'h00);
    io_read(10'h145, d, oe); chk("R1 mode", d, 8'h00);
    host_addr = 22'h0A0000; #1; chk("R1 cs", mem_cs, 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      io_write(10'h145, VEC[i][57:50]);
      io_write(10'h144, {2'b00, VEC[i][49:44]});
      @(negedge clk);
      host_addr = VEC[i][43:22];
      #1;
      chk($sformatf("R7-R11 vec%0d cs", i), mem_cs, VEC[i][21]);
      if (VEC[i][21]) chk($sformatf("R10 R11 vec%0d addr", i), mem_addr, VEC[i][20:0]);
    end

    // R12 host address change with no clock edge
    io_write(10'h145, 8'h40);
    io_write(10'h144, 8'h03);
    @(posedge clk); #2;
    host_addr = 22'h0A0004; #1;
    chk("R12 cs rise", mem_cs, 1);
    chk("R12 addr", mem_addr, 21'h018004);
    host_addr = 22'h0C0004; #1;
    chk("R12 cs fall", mem_cs, 0);

    // R3 upper page bits
    io_write(10'h144, 8'hFF);
    io_read(10'h144, d, oe); chk("R3 page mask", d, 8'h3F);
    // R4 reserved bit
    io_write(10'h145, 8'hFF);
    io_read(10'h145, d, oe); chk("R4 mode rsvd", d, 8'hEF);
    io_write(10'h145, 8'h2A);
    io_read(10'h145, d, oe); chk("R4 mode fields", d, 8'h2A);

    // R5 status
    led_red = 1; led_green = 0;
    io_read(10'h143, d, oe); chk("R5 red", d, 8'h01); chk("R5 oe", oe, 1);
    led_red = 0; led_green = 1;
    io_read(10'h143, d, oe); chk("R5 green", d, 8'h02);
    io_write(10'h143, 8'hFF);
    io_read(10'h143, d, oe); chk("R5 write ignored", d, 8'h02);

    // R6 unmapped offsets
    io_read(10'h140, d, oe); chk("R6 ofs0 oe", oe, 0); chk("R6 ofs0 data", d, 0);
    io_read(10'h146, d, oe); chk("R6 ofs6 oe", oe, 0);
    io_read(10'h147, d, oe); chk("R6 ofs7 oe", oe, 0);

    // R2 base selection
    io_write(10'h144, 8'h11);
    io_base_cfg = 2'b01;
    io_write(10'h144, 8'h22);  // outside block now
    io_read(10'h14C, d, oe); chk("R2 cfg01 page", d, 8'h11);
    io_read(10'h144, d, oe); chk("R2 old base oe", oe, 0);
    io_base_cfg = 2'b10;
    io_read(10'h164, d, oe); chk("R2 cfg10 page", d, 8'h11);
    io_base_cfg = 2'b11;
    io_write(10'h16C, 8'h07);
    io_read(10'h16C, d, oe); chk("R2 cfg11 page", d, 8'h07);
    io_read(10'h148, d, oe); chk("R2 other block oe", oe, 0);
    io_base_cfg = 2'b00;

    // R1 reset mid-run
    io_write(10'h145, 8'h80);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    io_read(10'h145, d, oe); chk("R1 mode after reset", d, 8'h00);
    io_read(10'h144, d, oe); chk("R1 page after reset", d, 8'h00);
    host_addr = 22'h3FFFFF; #1; chk("R1 cs after reset", mem_cs, 0);

    finish_run();
  end
endmodule